// File: doc/BRIEF.md
# UART Interrupt Status Combiner

This block keeps the raw interrupt status of a serial port and the enable mask that goes with it. Detector logic around it signals events with one-cycle set pulses. The block latches each event into an eleven-bit status word. Software clears status bits with a write-one-to-clear port and selects the events it cares about through a mask write port. The block presents the raw and masked status as 32-bit words for register reads.

From the masked status it drives six registered interrupt lines. Line 0 is the OR of every masked event. Lines 1 to 5 each carry one group: receive, transmit, receive timeout, modem status and error. The modem and error groups each collect four status bits. The other groups each carry a single bit. An integrator can wire the combined line alone, or route the group lines to separate interrupt inputs. Each line is registered, so it follows its masked group one clock later.

Top module: `uart_irq_combiner`

## Requirements
- R1: Status bit positions are fixed: ring 0, CTS 1, DCD 2, DSR 3, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10. A set pulse on `set_pulse[i]` sets `raw_status[i]`.
- R2: A set pulse sampled at a rising edge shows in `raw_status` right after that edge. A status bit then stays at 1 until a clear write removes it.
- R3: A clear write (`clr_we`=1) clears every raw bit whose `clr_wdata` bit is 1, at the same edge. Bits written as 0 keep their value.
- R4: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: `masked_status` is `raw_status` ANDed with the enable mask. It reflects the registers present after the latest edge.
- R6: `irq_out[0]` is 1 one cycle after any bit of `masked_status` is 1, and is 0 one cycle after none is.
- R7: Each group line is driven one cycle after its masked group: `irq_out[1]` from masked bit 4, `irq_out[2]` from bit 5, `irq_out[3]` from bit 6, `irq_out[4]` from the OR of bits 3..0, and `irq_out[5]` from the OR of bits 10..7.
- R8: A mask write (`mask_we`=1) loads `mask_wdata[10:0]` at the edge. `masked_status` reflects the new mask right after that edge, and the lines follow one cycle later, with no change to the raw status.
- R9: While reset is held, and after it is released, raw status, mask and all six lines are 0.
- R10: Bits 31..11 of `raw_status` and `masked_status` always read 0. The same bits of the write data have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| set_pulse | input | 11 | One-cycle event pulses, one per status bit |
| mask_we | input | 1 | Enable-mask write strobe |
| mask_wdata | input | 32 | Enable-mask write data |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_wdata | input | 32 | Clear data: a 1 clears that status bit |
| raw_status | output | 32 | Raw status, zero-extended |
| masked_status | output | 32 | Raw status ANDed with the mask, zero-extended |
| irq_out | output | 6 | 0 combined, 1 receive, 2 transmit, 3 timeout, 4 modem, 5 error |

## Verification
Events are first latched with the mask closed. This shows that raw capture does not depend on enabling. Opening the mask then shows that the lines react only through the mask, one cycle late. Single events are set in each group, and a full set of all eleven bits follows. These show whether each group line ORs exactly its own bits and no neighbour's. A partial clear, a set and clear colliding on one bit, and a narrow mask separate correct clear, priority and masking from designs that clear too much, let the clear win, or ignore the mask. All-ones write data shows that the upper bits never reach the status.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int STAT_W  = 11;
  localparam int NUM_IRQ = 6;

  typedef logic [STAT_W-1:0] stat_t;

  localparam int B_RING  = 0;
  localparam int B_CTS   = 1;
  localparam int B_DCD   = 2;
  localparam int B_DSR   = 3;
  localparam int B_RX    = 4;
  localparam int B_TX    = 5;
  localparam int B_RXTO  = 6;
  localparam int B_FRAME = 7;
  localparam int B_PAR   = 8;
  localparam int B_BREAK = 9;
  localparam int B_OVR   = 10;

  localparam stat_t GRP_MODEM = stat_t'((1 << B_RING) | (1 << B_CTS) | (1 << B_DCD) | (1 << B_DSR));
  localparam stat_t GRP_ERR   = stat_t'((1 << B_FRAME) | (1 << B_PAR) | (1 << B_BREAK) | (1 << B_OVR));
  localparam stat_t GRP_ALL   = '1;

  // line order: combined, receive, transmit, timeout, modem, error
  function automatic stat_t line_mask(input int idx);
    case (idx)
      0:       line_mask = GRP_ALL;
      1:       line_mask = stat_t'(1 << B_RX);
      2:       line_mask = stat_t'(1 << B_TX);
      3:       line_mask = stat_t'(1 << B_RXTO);
      4:       line_mask = GRP_MODEM;
      default: line_mask = GRP_ERR;
    endcase
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] raw_q;
  logic [W-1:0] raw_d;
  logic [W-1:0] clr_eff;
  logic         upd_en;

  always_comb begin
    clr_eff = clr_en_i ? clr_bits_i : '0;
    // a set pulse overrides a clear on the same bit
    raw_d   = (raw_q & ~clr_eff) | set_i;
    upd_en  = clr_en_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (upd_en) raw_q <= raw_d;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
  import uart_irq_pkg::*;
#(
  parameter int W     = STAT_W,
  parameter int LINES = NUM_IRQ
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     masked_i,
  output logic [LINES-1:0] irq_o
);
  logic [LINES-1:0] irq_d;
  logic [LINES-1:0] irq_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam stat_t SEL = line_mask(g);
    always_comb irq_d[g] = |(masked_i & W'(SEL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [STAT_W-1:0]     set_pulse,
  input  logic                  mask_we,
  input  logic [DATA_W-1:0]     mask_wdata,
  input  logic                  clr_we,
  input  logic [DATA_W-1:0]     clr_wdata,
  output logic [DATA_W-1:0]     raw_status,
  output logic [DATA_W-1:0]     masked_status,
  output logic [NUM_IRQ-1:0]    irq_out
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic        rst_sync_n;
  stat_t       raw_q;
  stat_t       mask_q;
  stat_t       masked;
  logic        unused_hi;

  assign unused_hi = ^{mask_wdata[DATA_W-1:STAT_W], clr_wdata[DATA_W-1:STAT_W]};

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_status_reg #(.W(STAT_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .set_i      (set_pulse),
    .clr_en_i   (clr_we),
    .clr_bits_i (clr_wdata[STAT_W-1:0]),
    .raw_o      (raw_q)
  );

  irq_mask_reg #(.W(STAT_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (mask_we),
    .wdata_i (mask_wdata[STAT_W-1:0]),
    .mask_o  (mask_q)
  );

  assign masked = raw_q & mask_q;

  irq_line_gen #(.W(STAT_W), .LINES(NUM_IRQ)) u_lines (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .masked_i (masked),
    .irq_o    (irq_out)
  );

  assign raw_status    = {{PAD_W{1'b0}}, raw_q};
  assign masked_status = {{PAD_W{1'b0}}, masked};
endmodule

// File: rtl/uart_irq_combiner_chk.sv
module uart_irq_combiner_chk
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [STAT_W-1:0]   set_pulse,
  input logic                mask_we,
  input logic [DATA_W-1:0]   mask_wdata,
  input logic                clr_we,
  input logic [DATA_W-1:0]   clr_wdata,
  input logic [DATA_W-1:0]   raw_status,
  input logic [DATA_W-1:0]   masked_status,
  input logic [NUM_IRQ-1:0]  irq_out
);
  // R1, R2 and R4: every pulsed bit is set after the edge, whatever the clear did
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_pulse) |=> ((raw_status[STAT_W-1:0] & $past(set_pulse)) == $past(set_pulse)));

  // R3: cleared bits not pulsed are 0
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((raw_status[STAT_W-1:0] & $past(clr_wdata[STAT_W-1:0]) & ~$past(set_pulse)) == '0));

  // R2: no set, no clear -> raw status holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse == '0 && !clr_we) |=> $stable(raw_status));

  // R5: masked bits are a subset of raw bits
  a_r5_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_status & ~raw_status) == '0);

  // R8: a mask write takes effect on the masked status at once
  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (masked_status[STAT_W-1:0] ==
                 (raw_status[STAT_W-1:0] & $past(mask_wdata[STAT_W-1:0]))));

  // R10: upper bits read 0
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[DATA_W-1:STAT_W] == '0) && (masked_status[DATA_W-1:STAT_W] == '0));

  // R6: combined line
  a_r6_combined: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(masked_status) |=> (irq_out[0] == (|$past(masked_status[STAT_W-1:0]))));

  // R7: group lines
  a_r7_rx: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(masked_status) |=> (irq_out[1] == $past(masked_status[4])));
  a_r7_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(masked_status) |=> (irq_out[2] == $past(masked_status[5])));
  a_r7_rxto: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(masked_status) |=> (irq_out[3] == $past(masked_status[6])));
  a_r7_modem: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(masked_status) |=> (irq_out[4] == (|$past(masked_status[3:0]))));
  a_r7_err: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(masked_status) |=> (irq_out[5] == (|$past(masked_status[10:7]))));
endmodule

bind uart_irq_combiner uart_irq_combiner_chk #(.DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .set_pulse     (set_pulse),
  .mask_we       (mask_we),
  .mask_wdata    (mask_wdata),
  .clr_we        (clr_we),
  .clr_wdata     (clr_wdata),
  .raw_status    (raw_status),
  .masked_status (masked_status),
  .irq_out       (irq_out)
);

// File: tb/uart_irq_combiner_tb_top.sv
module uart_irq_combiner_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] set_pulse = '0;
  logic        mask_we = 1'b0;
  logic [31:0] mask_wdata = '0;
  logic        clr_we = 1'b0;
  logic [31:0] clr_wdata = '0;
  logic [31:0] raw_status;
  logic [31:0] masked_status;
  logic [5:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] raw;
    logic [31:0] msk;
    logic [5:0]  irq;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  logic [10:0] m_raw  = '0;
  logic [10:0] m_mask = '0;

  always #4 clk = ~clk;  // 125 MHz

  uart_irq_combiner dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_pulse     (set_pulse),
    .mask_we       (mask_we),
    .mask_wdata    (mask_wdata),
    .clr_we        (clr_we),
    .clr_wdata     (clr_wdata),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq_out       (irq_out)
  );

  function automatic logic [5:0] lines_of(input logic [10:0] m);
    lines_of = {|m[10:7], |m[3:0], m[6], m[5], m[4], |m};
  endfunction

  // driver: applies one cycle of stimulus and predicts the state after the edge
  task automatic step(input logic [10:0] s, input logic mw, input logic [31:0] md,
                      input logic cw, input logic [31:0] cd, input string tag);
    exp_t e;
    logic [10:0] nraw;
    logic [10:0] nmask;
    @(negedge clk);
    set_pulse  = s;
    mask_we    = mw;
    mask_wdata = md;
    clr_we     = cw;
    clr_wdata  = cd;
    nraw  = (m_raw & ~(cw ? cd[10:0] : 11'h0)) | s;
    nmask = mw ? md[10:0] : m_mask;
    e.irq = lines_of(m_raw & m_mask);
    e.raw = {21'h0, nraw};
    e.msk = {21'h0, nraw & nmask};
    e.tag = tag;
    exp_q.push_back(e);
    m_raw  = nraw;
    m_mask = nmask;
  endtask

  task automatic idle(input string tag);
    step(11'h0, 1'b0, 32'h0, 1'b0, 32'h0, tag);
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (raw_status !== e.raw || masked_status !== e.msk || irq_out !== e.irq) begin
        errors++;
        $display("FAIL %s raw %h exp %h masked %h exp %h irq %b exp %b",
                 e.tag, raw_status, e.raw, masked_status, e.msk, irq_out, e.irq);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: state while reset is held
    checks++;
    if (raw_status !== 32'h0 || masked_status !== 32'h0 || irq_out !== 6'h0) begin
      errors++;
      $display("FAIL R9 in reset raw %h masked %h irq %b exp 0 0 0",
               raw_status, masked_status, irq_out);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (raw_status !== 32'h0 || masked_status !== 32'h0 || irq_out !== 6'h0) begin
      errors++;
      $display("FAIL R9 after reset raw %h masked %h irq %b exp 0 0 0",
               raw_status, masked_status, irq_out);
    end

    step(11'h010, 1'b0, 32'h0, 1'b0, 32'h0, "R1 R2 rx set with mask closed");
    idle("R2 rx bit held");
    step(11'h0, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, "R8 R10 mask opened all ones");
    idle("R6 R7 rx line follows");
    step(11'h008, 1'b0, 32'h0, 1'b0, 32'h0, "R7 modem via dsr");
    step(11'h200, 1'b0, 32'h0, 1'b0, 32'h0, "R7 error via break");
    step(11'h0, 1'b0, 32'h0, 1'b1, 32'h0000_0010, "R3 partial clear of rx");
    idle("R3 others kept");
    step(11'h020, 1'b0, 32'h0, 1'b1, 32'h0000_0020, "R4 set beats clear");
    step(11'h0, 1'b0, 32'h0, 1'b1, 32'hFFFF_F800, "R10 upper clear bits ignored");
    step(11'h040, 1'b1, 32'h0000_0040, 1'b0, 32'h0, "R5 R8 narrow mask timeout");
    idle("R7 timeout line only");
    step(11'h0, 1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF, "R3 clear all");
    idle("R6 lines drop");
    step(11'h0, 1'b1, 32'h0000_07FF, 1'b0, 32'h0, "R8 mask wide no raw");
    step(11'h7FF, 1'b0, 32'h0, 1'b0, 32'h0, "R1 all bits set");
    idle("R7 all groups high");
    step(11'h001, 1'b0, 32'h0, 1'b1, 32'h0000_07FE, "R4 R7 ring only kept");
    idle("R7 modem from ring");
    step(11'h0, 1'b1, 32'h0000_0780, 1'b0, 32'h0, "R8 mask to error group");
    idle("R6 mask hides ring");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule